// File: doc/BRIEF.md
# Serial Flash Write Guard

This block is the command-acceptance gate that sits between the instruction decoder of a serial NOR flash and its program/erase engine. It receives an opcode with a strobe and a target address for each instruction. It decides at once whether the instruction is accepted or dropped, and it reports that decision as a one-cycle accept or reject pulse. It also keeps the state that drives those decisions: the write-enable latch, the five status protection bits, the busy flag of a running operation, a post-power-up lockout timer and the power-down state.

The supply-good input works as a second reset. While it is low, nothing is accepted and the volatile state is cleared. Once it rises, write-class instructions stay locked out for `LOCK_CYC` cycles. After the lockout, every modifying operation needs the write-enable latch set first. The status protection bits choose a region at the top or at the bottom of the array that cannot be written. A protect bit together with the write-protect pin can freeze the status bits.

Top module: `flash_wr_guard`

## Requirements
- R1: While `supply_ok` is low, no accept or reject pulse is produced, and `wel_o`, `pd_o` and `busy_o` are 0. `sr_o` keeps its value and is cleared only by `rst_n`.
- R2: For the first `LOCK_CYC` clock edges with `supply_ok` high, the write-class opcodes are rejected and `lock_o` is 1. The write-class opcodes are 06h, 02h, 20h, D8h, C7h and 01h.
- R3: `wel_o` is 0 after reset. An accepted 06h (write enable) sets it and an accepted 04h (write disable) clears it.
- R4: Page program (02h), sector erase (20h), block erase (D8h), chip erase (C7h) and status write (01h) are rejected when `wel_o` is 0, and a rejected instruction changes no state.
- R5: An accepted 02h/20h/D8h/C7h/01h sets `busy_o`. An `op_done` pulse while `busy_o` is 1 clears both `busy_o` and `wel_o` on the same edge.
- R6: An accepted 01h loads `sr_o` from `sr_wdata`, laid out as bit 4 = freeze bit, bit 3 = bottom select, bits 2:0 = region code. When the freeze bit is 1 and `wp_n` is 0, 01h is rejected and `wel_o` stays unchanged.
- R7: With region code n > 0, the protected region is 2^(ADDR_W-7+n) bytes. It sits at the top of the array when the bottom select bit is 0 and at the bottom when it is 1, so code 7 protects the whole array. 02h/20h/D8h aimed at a protected address are rejected. 0C7h is rejected whenever n is not 0.
- R8: An accepted B9h enters power-down (`pd_o`=1). In power-down every opcode except ABh is rejected, and ABh is accepted and leaves power-down. ABh outside power-down is accepted with no effect.
- R9: Each strobe sampled with `supply_ok` high gives exactly one of `acc_o`/`rej_o` for one cycle after the sampling edge. Opcodes not listed are rejected.
- R10: While `busy_o` is 1, every opcode except 04h is rejected, including 06h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, clears all state |
| supply_ok | input | 1 | Supply above threshold; low holds volatile state in reset |
| wp_n | input | 1 | Active-low write-protect pin |
| op_valid | input | 1 | Opcode strobe |
| op_code | input | 8 | Decoded instruction opcode |
| op_addr | input | ADDR_W | Target address of program/erase |
| sr_wdata | input | 5 | Status write data {freeze, bottom, code[2:0]} |
| op_done | input | 1 | Program/erase/status-write completion pulse |
| acc_o | output | 1 | Instruction accepted pulse |
| rej_o | output | 1 | Instruction rejected pulse |
| wel_o | output | 1 | Write-enable latch |
| pd_o | output | 1 | Power-down state |
| busy_o | output | 1 | Operation in progress |
| lock_o | output | 1 | Power-up lockout active |
| sr_o | output | 5 | Status protection bits {freeze, bottom, code[2:0]} |

## Verification
Every result is registered once. The accept/reject pulse and the updated latch, busy, power-down and status bits all appear right after the clock edge that sampled the strobe or `op_done`, and they are gone or stable by the edge after that. The bench drives inputs at the falling edge, steps a behavioural model at the rising edge, and compares every output at the next falling edge, which is exactly one edge of latency. The lockout boundary is checked on the last locked edge and on the first free edge after `supply_ok` rises.

// File: rtl/fg_pkg.sv
// Shared opcodes, status layout and action codes for the flash write guard.
// Assumes an 8-bit opcode that has already been decoded from the serial stream.
package fg_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_PP   = 8'h02;
    localparam logic [7:0] OP_SE   = 8'h20;
    localparam logic [7:0] OP_BE   = 8'hD8;
    localparam logic [7:0] OP_CE   = 8'hC7;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_PD   = 8'hB9;
    localparam logic [7:0] OP_RPD  = 8'hAB;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_SET_WEL,
        ACT_CLR_WEL,
        ACT_START,
        ACT_LOAD_SR,
        ACT_SLEEP,
        ACT_WAKE
    } act_e;

    typedef struct packed {
        logic       frz;
        logic       bot;
        logic [2:0] code;
    } sr_t;
endpackage

// File: rtl/fg_lockout.sv
// Power-up lockout timer: reloads while supply is low or reset is active,
// then counts LOCK_CYC edges down and reports locked until it reaches zero.
module fg_lockout #(
    parameter int LOCK_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic locked
);
    localparam int CW = $clog2(LOCK_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(LOCK_CYC);

    logic [CW-1:0] cnt_q;

    // Count down after supply is good; reload on any reset condition.
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign locked = (cnt_q != '0);
endmodule

// File: rtl/fg_region.sv
// Protected-region test: decides whether an address lies in the top or bottom
// slice chosen by the region code. Assumes ADDR_W >= 7 so code 1 is >= 1 byte.
module fg_region #(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              bot,
    input  logic [2:0]        code,
    output logic              hit
);
    localparam int BASE = ADDR_W - 7;

    logic [ADDR_W:0]   span;
    logic [ADDR_W-1:0] low_mask;
    logic [ADDR_W-1:0] hi_bits;

    // Region of 2^(BASE+code) bytes; high address bits decide membership.
    always_comb begin
        span     = (ADDR_W+1)'(1) << (BASE + int'(code));
        low_mask = ADDR_W'(span - 1'b1);
        hi_bits  = addr & ~low_mask;
        if (code == 3'd0) begin
            hit = 1'b0;
        end else if (bot) begin
            hit = (hi_bits == '0);
        end else begin
            hit = (hi_bits == ~low_mask);
        end
    end
endmodule

// File: rtl/fg_decide.sv
// Combinational accept/reject decision for one opcode given the current
// guard state. Priority: power-down, then busy, then lockout, then opcode rules.
module fg_decide
    import fg_pkg::*;
(
    input  logic [7:0] code,
    input  logic       pd,
    input  logic       busy,
    input  logic       locked,
    input  logic       wel,
    input  logic       frz,
    input  logic       wp_n,
    input  logic       any_prot,
    input  logic       in_region,
    output logic       ok,
    output act_e       act
);
    logic wr_class;

    // Write-class opcodes are the ones blocked by the power-up lockout.
    always_comb begin
        wr_class = (code == OP_WREN) || (code == OP_PP) || (code == OP_SE) ||
                   (code == OP_BE)   || (code == OP_CE) || (code == OP_WRSR);
    end

    // Resolve the opcode to an accept flag and a state action.
    always_comb begin
        ok  = 1'b0;
        act = ACT_NONE;
        if (pd) begin
            if (code == OP_RPD) begin
                ok  = 1'b1;
                act = ACT_WAKE;
            end
        end else if (busy) begin
            if (code == OP_WRDI) begin
                ok  = 1'b1;
                act = ACT_CLR_WEL;
            end
        end else if (!(locked && wr_class)) begin
            case (code)
                OP_WREN: begin ok = 1'b1; act = ACT_SET_WEL; end
                OP_WRDI: begin ok = 1'b1; act = ACT_CLR_WEL; end
                OP_PD:   begin ok = 1'b1; act = ACT_SLEEP;   end
                OP_RPD:  begin ok = 1'b1; act = ACT_NONE;    end
                OP_PP, OP_SE, OP_BE: begin
                    ok  = wel && !in_region;
                    act = ACT_START;
                end
                OP_CE: begin
                    ok  = wel && !any_prot;
                    act = ACT_START;
                end
                OP_WRSR: begin
                    ok  = wel && !(frz && !wp_n);
                    act = ACT_LOAD_SR;
                end
                default: begin ok = 1'b0; act = ACT_NONE; end
            endcase
        end
    end
endmodule

// File: rtl/flash_wr_guard.sv
// Write-protection and command-acceptance gate of a serial NOR flash.
// Assumes opcodes arrive pre-decoded with a one-cycle strobe and that the
// program/erase engine reports completion with op_done.
module flash_wr_guard
    import fg_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int LOCK_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              wp_n,
    input  logic              op_valid,
    input  logic [7:0]        op_code,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [4:0]        sr_wdata,
    input  logic              op_done,
    output logic              acc_o,
    output logic              rej_o,
    output logic              wel_o,
    output logic              pd_o,
    output logic              busy_o,
    output logic              lock_o,
    output logic [4:0]        sr_o
);
    sr_t  sr_q;
    logic wel_q, pd_q, busy_q, acc_q, rej_q;
    logic locked, in_region, ok, fire;
    act_e act;

    fg_lockout #(.LOCK_CYC(LOCK_CYC)) i_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .locked    (locked)
    );

    fg_region #(.ADDR_W(ADDR_W)) i_region (
        .addr (op_addr),
        .bot  (sr_q.bot),
        .code (sr_q.code),
        .hit  (in_region)
    );

    fg_decide i_decide (
        .code      (op_code),
        .pd        (pd_q),
        .busy      (busy_q),
        .locked    (locked),
        .wel       (wel_q),
        .frz       (sr_q.frz),
        .wp_n      (wp_n),
        .any_prot  (sr_q.code != 3'd0),
        .in_region (in_region),
        .ok        (ok),
        .act       (act)
    );

    assign fire = op_valid && ok;

    // Status bits survive supply loss; only the full reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (supply_ok && fire && act == ACT_LOAD_SR) begin
            sr_q <= sr_t'(sr_wdata);
        end
    end

    // Volatile guard state and the per-strobe decision pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok) begin
            wel_q  <= 1'b0;
            pd_q   <= 1'b0;
            busy_q <= 1'b0;
            acc_q  <= 1'b0;
            rej_q  <= 1'b0;
        end else begin
            acc_q <= fire;
            rej_q <= op_valid && !ok;
            if (busy_q && op_done) begin
                wel_q <= 1'b0;
            end else if (fire && act == ACT_SET_WEL) begin
                wel_q <= 1'b1;
            end else if (fire && act == ACT_CLR_WEL) begin
                wel_q <= 1'b0;
            end
            if (fire && (act == ACT_START || act == ACT_LOAD_SR)) begin
                busy_q <= 1'b1;
            end else if (op_done) begin
                busy_q <= 1'b0;
            end
            if (fire && act == ACT_SLEEP) begin
                pd_q <= 1'b1;
            end else if (fire && act == ACT_WAKE) begin
                pd_q <= 1'b0;
            end
        end
    end

    assign acc_o  = acc_q;
    assign rej_o  = rej_q;
    assign wel_o  = wel_q;
    assign pd_o   = pd_q;
    assign busy_o = busy_q;
    assign lock_o = locked;
    assign sr_o   = sr_q;
endmodule

// File: rtl/fg_checker.sv
// Temporal checks on the guard's ports; attached to every flash_wr_guard by bind.
module fg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_ok,
    input logic       wp_n,
    input logic       op_valid,
    input logic [7:0] op_code,
    input logic       op_done,
    input logic       acc_o,
    input logic       rej_o,
    input logic       wel_o,
    input logic       pd_o,
    input logic       busy_o,
    input logic       lock_o,
    input logic [4:0] sr_o
);
    a_r1_supply_low: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!wel_o && !pd_o && !busy_o && !acc_o && !rej_o));

    a_r2_lock_rejects_wren: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && supply_ok && op_valid && op_code == 8'h06) |=> rej_o);

    a_r3_wel_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_o) |-> $past(op_valid && op_code == 8'h06));

    a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && op_done && supply_ok) |=> (!busy_o && !wel_o));

    a_r6_frozen_status: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_o[4] && !wp_n) |=> $stable(sr_o));

    a_r8_pd_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_o && supply_ok && op_valid && op_code != 8'hAB) |=> rej_o);

    a_r9_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_o && rej_o));

    a_r9_strobe_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && supply_ok) |=> (acc_o || rej_o));

    a_r10_busy_wren: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !pd_o && supply_ok && op_valid && op_code == 8'h06) |=> rej_o);
endmodule

bind flash_wr_guard fg_checker i_fg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .wp_n      (wp_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_done   (op_done),
    .acc_o     (acc_o),
    .rej_o     (rej_o),
    .wel_o     (wel_o),
    .pd_o      (pd_o),
    .busy_o    (busy_o),
    .lock_o    (lock_o),
    .sr_o      (sr_o)
);

// File: tb/test_flash_wr_guard.sv
module test_flash_wr_guard;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int LOCK_CYC   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              supply_ok = 1'b0;
    logic              wp_n = 1'b1;
    logic              op_valid = 1'b0;
    logic [7:0]        op_code = 8'h00;
    logic [ADDR_W-1:0] op_addr = '0;
    logic [4:0]        sr_wdata = '0;
    logic              op_done = 1'b0;
    logic acc_o, rej_o, wel_o, pd_o, busy_o, lock_o;
    logic [4:0] sr_o;

    int n_checks = 0;
    int n_fail   = 0;

    // behavioural reference state
    int m_wel = 0, m_pd = 0, m_busy = 0, m_acc = 0, m_rej = 0, m_sr = 0;
    int m_lock = LOCK_CYC;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_wr_guard #(.ADDR_W(ADDR_W), .LOCK_CYC(LOCK_CYC)) i_flash_wr_guard (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wp_n(wp_n),
        .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr),
        .sr_wdata(sr_wdata), .op_done(op_done),
        .acc_o(acc_o), .rej_o(rej_o), .wel_o(wel_o), .pd_o(pd_o),
        .busy_o(busy_o), .lock_o(lock_o), .sr_o(sr_o)
    );

    function automatic bit protected_addr(int addr, int sr);
        int code = sr & 7;
        int size;
        if (code == 0) return 0;
        size = 1 << (ADDR_W - 7 + code);
        if ((sr >> 3) & 1) return addr < size;
        return addr >= ((1 << ADDR_W) - size);
    endfunction

    task automatic model_step();
        int c = op_code;
        bit wrc, ok;
        int act; // 0 none 1 set 2 clr 3 start 4 loadsr 5 sleep 6 wake
        if (!rst_n) begin
            m_wel = 0; m_pd = 0; m_busy = 0; m_acc = 0; m_rej = 0; m_sr = 0;
            m_lock = LOCK_CYC;
            return;
        end
        if (!supply_ok) begin
            m_wel = 0; m_pd = 0; m_busy = 0; m_acc = 0; m_rej = 0;
            m_lock = LOCK_CYC;
            return;
        end
        wrc = (c == 8'h06) || (c == 8'h02) || (c == 8'h20) || (c == 8'hD8) ||
              (c == 8'hC7) || (c == 8'h01);
        ok = 0; act = 0;
        if (m_pd != 0) begin
            if (c == 8'hAB) begin ok = 1; act = 6; end
        end else if (m_busy != 0) begin
            if (c == 8'h04) begin ok = 1; act = 2; end
        end else if (!(m_lock > 0 && wrc)) begin
            if (c == 8'h06) begin ok = 1; act = 1; end
            else if (c == 8'h04) begin ok = 1; act = 2; end
            else if (c == 8'hB9) begin ok = 1; act = 5; end
            else if (c == 8'hAB) begin ok = 1; act = 0; end
            else if (c == 8'h02 || c == 8'h20 || c == 8'hD8) begin
                ok = (m_wel != 0) && !protected_addr(int'(op_addr), m_sr); act = 3;
            end else if (c == 8'hC7) begin
                ok = (m_wel != 0) && ((m_sr & 7) == 0); act = 3;
            end else if (c == 8'h01) begin
                ok = (m_wel != 0) && !(((m_sr >> 4) & 1) == 1 && !wp_n); act = 4;
            end
        end
        m_acc = (op_valid && ok) ? 1 : 0;
        m_rej = (op_valid && !ok) ? 1 : 0;
        if (m_busy != 0 && op_done) begin
            m_busy = 0; m_wel = 0;
        end
        if (op_valid && ok) begin
            case (act)
                1: m_wel = 1;
                2: m_wel = 0;
                3: m_busy = 1;
                4: begin m_busy = 1; m_sr = int'(sr_wdata); end
                5: m_pd = 1;
                6: m_pd = 0;
                default: ;
            endcase
        end
        if (m_lock > 0) m_lock--;
    endtask

    // One clock: drive at negedge, step model at posedge, compare at next negedge.
    task automatic cyc(string tag, bit v, logic [7:0] c, int a = 0, int wd = 0, bit d = 0);
        logic [10:0] got, exp;
        op_valid = v; op_code = c; op_addr = ADDR_W'(a); sr_wdata = 5'(wd); op_done = d;
        @(posedge clk);
        model_step();
        @(negedge clk);
        got = {acc_o, rej_o, wel_o, pd_o, busy_o, lock_o, sr_o};
        exp = {m_acc[0], m_rej[0], m_wel[0], m_pd[0], m_busy[0], (m_lock != 0), 5'(m_sr)};
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got acc,rej,wel,pd,busy,lock,sr=%b expected %b", tag, got, exp);
        end
        op_valid = 0; op_done = 0;
    endtask

    // Targeted check of one output against a literal expectation.
    task automatic expect_bit(string tag, logic act_v, logic exp_v);
        n_checks++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act_v, exp_v);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL R9 watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        // reset state (R1, R3)
        rst_n = 0;
        repeat (3) cyc("R1 reset", 0, 8'h00);
        expect_bit("R3 wel after reset", wel_o, 1'b0);
        rst_n = 1;
        // supply low: strobes produce nothing (R1)
        cyc("R1 supply low wren", 1, 8'h06);
        cyc("R1 supply low pd", 1, 8'hB9);
        expect_bit("R1 no pulse while supply low", acc_o | rej_o, 1'b0);
        // lockout window (R2)
        supply_ok = 1;
        cyc("R2 first edge wren", 1, 8'h06);
        expect_bit("R2 lock active", lock_o, 1'b1);
        for (int i = 0; i < LOCK_CYC - 2; i++) cyc("R2 idle", 0, 8'h00);
        cyc("R2 last locked edge", 1, 8'h06);
        expect_bit("R2 last locked edge rejected", rej_o, 1'b1);
        cyc("R4 pp without wel", 1, 8'h02, 16'h100);
        expect_bit("R4 pp without wel no busy", busy_o, 1'b0);
        cyc("R3 wren after lock", 1, 8'h06);
        expect_bit("R3 wel set", wel_o, 1'b1);
        // program, busy behaviour, completion (R5, R10)
        cyc("R5 pp accept", 1, 8'h02, 16'h100);
        cyc("R10 wren busy", 1, 8'h06);
        cyc("R10 pd busy", 1, 8'hB9);
        cyc("R5 idle busy", 0, 8'h00);
        cyc("R5 done", 0, 8'h00, 0, 0, 1);
        expect_bit("R5 wel cleared by done", wel_o, 1'b0);
        // status write: freeze=1, top, code 2 -> top 128 bytes (R6, R7)
        cyc("R3 wren", 1, 8'h06);
        cyc("R6 wrsr", 1, 8'h01, 0, 5'b10010);
        cyc("R5 done", 0, 8'h00, 0, 0, 1);
        cyc("R3 wren", 1, 8'h06);
        cyc("R7 pp top protected", 1, 8'h02, 12'hF80);
        expect_bit("R7 top boundary rejected", rej_o, 1'b1);
        cyc("R7 pp just below", 1, 8'h02, 12'hF7F);
        cyc("R5 done", 0, 8'h00, 0, 0, 1);
        cyc("R3 wren", 1, 8'h06);
        cyc("R7 chip erase with protection", 1, 8'hC7);
        // frozen status with wp_n low (R6)
        wp_n = 0;
        cyc("R6 wrsr frozen", 1, 8'h01, 0, 5'b00000);
        expect_bit("R6 wel unchanged", wel_o, 1'b1);
        wp_n = 1;
        cyc("R6 wrsr bottom code1", 1, 8'h01, 0, 5'b01001);
        cyc("R5 done", 0, 8'h00, 0, 0, 1);
        cyc("R3 wren", 1, 8'h06);
        cyc("R7 se bottom protected", 1, 8'h20, 12'h03F);
        cyc("R7 be above bottom", 1, 8'hD8, 12'h040);
        cyc("R5 done", 0, 8'h00, 0, 0, 1);
        // write disable (R3)
        cyc("R3 wren", 1, 8'h06);
        cyc("R3 wrdi", 1, 8'h04);
        expect_bit("R3 wel cleared by wrdi", wel_o, 1'b0);
        // power-down (R8)
        cyc("R8 rpd when awake", 1, 8'hAB);
        cyc("R8 enter pd", 1, 8'hB9);
        cyc("R8 wren in pd", 1, 8'h06);
        cyc("R8 wrdi in pd", 1, 8'h04);
        expect_bit("R8 wrdi rejected in pd", rej_o, 1'b1);
        cyc("R8 release", 1, 8'hAB);
        expect_bit("R8 pd left", pd_o, 1'b0);
        // unknown opcode (R9)
        cyc("R9 unknown opcode", 1, 8'h9F);
        expect_bit("R9 unknown rejected", rej_o, 1'b1);
        // whole-array protection then none (R7)
        cyc("R3 wren", 1, 8'h06);
        cyc("R6 wrsr code7", 1, 8'h01, 0, 5'b00111);
        cyc("R5 done", 0, 8'h00, 0, 0, 1);
        cyc("R3 wren", 1, 8'h06);
        cyc("R7 pp at zero with code7", 1, 8'h02, 0);
        cyc("R6 wrsr clear", 1, 8'h01, 0, 5'b00000);
        cyc("R5 done", 0, 8'h00, 0, 0, 1);
        cyc("R3 wren", 1, 8'h06);
        cyc("R7 chip erase unprotected", 1, 8'hC7);
        cyc("R5 done", 0, 8'h00, 0, 0, 1);
        // supply drop keeps status, restarts lockout (R1, R2)
        cyc("R3 wren", 1, 8'h06);
        cyc("R6 wrsr bot code3", 1, 8'h01, 0, 5'b01011);
        supply_ok = 0;
        cyc("R1 supply drop", 0, 8'h00, 0, 0, 1);
        expect_bit("R1 status kept", sr_o[3], 1'b1);
        supply_ok = 1;
        cyc("R2 relock wren", 1, 8'h06);
        for (int i = 0; i < LOCK_CYC; i++) cyc("R2 idle", 0, 8'h00);
        cyc("R3 wren after relock", 1, 8'h06);
        // full reset clears status (R1)
        rst_n = 0;
        cyc("R1 reset clears status", 0, 8'h00);
        rst_n = 1;
        cyc("R1 after reset", 0, 8'h00);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule